// File: doc/BRIEF.md
# DMA Controller Host Command Decoder

This block is the programming front end of a four-channel DMA controller. A host reaches it through an active-low chip select, active-low read and write strobes and a 4-bit register address. Each write is turned into a register load or a one-shot command, and each read selects the data to return. The block holds the 8-bit control register, one software request flag and one mask flag per channel, and the pointer flip-flop that tracks which byte of a 16-bit channel register comes next. It also produces a one-cycle strobe for the mode register, which lives elsewhere.

Reads return one of two words. The first is a status word built from the per-channel terminal-count inputs and the pending requests. The second is a temporary-register value that comes in from the transfer engine. The flags and control bits are driven straight out to the arbitration and transfer logic, and neither of those is part of this block. The asynchronous reset input is released through a two-stage synchronizer. A master clear command has the same effect as a reset.

Top module: `dma_cmd_decoder`

## Requirements
- R1: After reset the control register is 0x00, all request flags are 0, all mask flags are 1 (mask_o = 4'hF), the pointer flip-flop is 0 and mode_wr_o is 0.
- R2: A write to address 0x8 loads wr_data_i into ctrl_o. The bits pass through unchanged: bit 0 enables memory-to-memory transfer, bit 1 holds the source address, bit 3 selects compressed timing and bit 5 stretches the write signals to two cycles.
- R3: A read of address 0x8 returns the status word {pending[3:0], tc_i[3:0]}, where pending[n] = dreq_i[n] | req_o[n]. Bit n holds the terminal count of channel n and bit n+4 shows a pending request on channel n.
- R4: A write to address 0x9 sets req_o[wr_data_i[1:0]] to wr_data_i[2]. The other channels and the other data bits have no effect.
- R5: A write to address 0xA sets mask_o[wr_data_i[1:0]] to wr_data_i[2]. The other channels and the other data bits have no effect.
- R6: A write to address 0xB raises mode_wr_o for exactly one cycle, in the cycle after the sampling edge, with mode_data_o equal to the written byte.
- R7: A write to address 0xC clears ptr_o and ignores the data. A ptr_toggle_i pulse inverts ptr_o. When both happen on the same edge, the clear wins.
- R8: A read of address 0xD returns temp_i. A write to address 0xD is a master clear that gives the R1 state and ignores the data.
- R9: A write to address 0xE clears all four mask flags. A write to address 0xF loads mask_o[3:0] from wr_data_i[3:0].
- R10: A write acts only on the edge where cs_n and wr_n are both sampled low after an edge where they were not. A strobe held low does nothing more. Writes with cs_n high, or to addresses 0x0 to 0x7, change nothing.
- R11: rd_data_o is combinational and is 0x00 unless cs_n and rd_n are low and the address is 0x8 or 0xD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Host read data |
| tc_i | input | 4 | Per-channel terminal-count state |
| dreq_i | input | 4 | Per-channel hardware request, already in positive polarity |
| temp_i | input | 8 | Temporary register value from the transfer engine |
| ptr_toggle_i | input | 1 | One-cycle pulse that advances the byte pointer |
| ctrl_o | output | 8 | Control register |
| req_o | output | 4 | Software request flags |
| mask_o | output | 4 | Mask flags |
| ptr_o | output | 1 | First/last byte pointer |
| mode_wr_o | output | 1 | One-cycle mode register write strobe |
| mode_data_o | output | 8 | Byte captured with the mode strobe |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit data and a 4-bit address. With four channels the channel select is two bits wide and the flag value sits in data bit 2, so a single-flag write that sets bits outside 2:0 shows whether the decoder ignores them. An 8-bit data bus holds exactly four terminal-count bits and four pending bits, so every status bit can be driven and observed. It also lets the bulk mask load use a data byte whose upper nibble is nonzero, which must not reach the flags.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  typedef enum logic [3:0] {
    ADR_CTRL_STAT = 4'h8,
    ADR_REQ_ONE   = 4'h9,
    ADR_MASK_ONE  = 4'hA,
    ADR_MODE      = 4'hB,
    ADR_PTR_CLR   = 4'hC,
    ADR_TEMP_MCLR = 4'hD,
    ADR_MASK_CLR  = 4'hE,
    ADR_MASK_ALL  = 4'hF
  } reg_addr_e;

  typedef struct packed {
    logic ctrl_we;
    logic req_we;
    logic mask_we;
    logic mode_we;
    logic ptr_clr;
    logic mclr;
    logic mask_clr;
    logic mask_all;
  } cmd_t;

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_cmd_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_i,
  output cmd_t          cmd_o,
  output logic          rd_stat_o,
  output logic          rd_temp_o
);

  logic wr_act, wr_prev_q, wr_prev_d, wr_fire;
  logic rd_act;

  assign wr_act  = !cs_n && !wr_n;
  assign rd_act  = !cs_n && !rd_n;
  assign wr_fire = wr_act && !wr_prev_q;

  always_comb begin
    wr_prev_d = wr_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_prev_d;
  end

  always_comb begin
    cmd_o          = '0;
    cmd_o.ctrl_we  = wr_fire && (addr_i == ADR_CTRL_STAT);
    cmd_o.req_we   = wr_fire && (addr_i == ADR_REQ_ONE);
    cmd_o.mask_we  = wr_fire && (addr_i == ADR_MASK_ONE);
    cmd_o.mode_we  = wr_fire && (addr_i == ADR_MODE);
    cmd_o.ptr_clr  = wr_fire && (addr_i == ADR_PTR_CLR);
    cmd_o.mclr     = wr_fire && (addr_i == ADR_TEMP_MCLR);
    cmd_o.mask_clr = wr_fire && (addr_i == ADR_MASK_CLR);
    cmd_o.mask_all = wr_fire && (addr_i == ADR_MASK_ALL);
  end

  assign rd_stat_o = rd_act && (addr_i == ADR_CTRL_STAT);
  assign rd_temp_o = rd_act && (addr_i == ADR_TEMP_MCLR);

  // R10: a write strobe held low fires only once
  p_single_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  // R10: at most one command decoded per edge
  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_o));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_cmd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_t          cmd_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ptr_toggle_i,
  output logic [DW-1:0] ctrl_o,
  output logic          ptr_o,
  output logic          mode_wr_o,
  output logic [DW-1:0] mode_data_o
);

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          ctrl_en;
  logic          ptr_q, ptr_d;
  logic          mode_wr_q, mode_wr_d;
  logic [DW-1:0] mode_data_q, mode_data_d;
  logic          mode_en;

  always_comb begin
    ctrl_en = cmd_i.ctrl_we || cmd_i.mclr;
    ctrl_d  = cmd_i.mclr ? '0 : wr_data_i;
  end

  always_comb begin
    if (cmd_i.mclr || cmd_i.ptr_clr) ptr_d = 1'b0;
    else if (ptr_toggle_i)           ptr_d = !ptr_q;
    else                             ptr_d = ptr_q;
  end

  always_comb begin
    mode_wr_d   = cmd_i.mode_we;
    mode_en     = cmd_i.mode_we;
    mode_data_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ptr_q       <= 1'b0;
      mode_wr_q   <= 1'b0;
      mode_data_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      ptr_q     <= ptr_d;
      mode_wr_q <= mode_wr_d;
      if (mode_en) mode_data_q <= mode_data_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign ptr_o       = ptr_q;
  assign mode_wr_o   = mode_wr_q;
  assign mode_data_o = mode_data_q;

  // R2: control holds its value without a load or clear
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i.ctrl_we && !cmd_i.mclr) |=> $stable(ctrl_q));

  // R8: master clear empties control and pointer
  p_mclr_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.mclr |=> (ctrl_q == '0) && !ptr_q);

  // R7: clear wins over toggle
  p_ptr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.ptr_clr |=> !ptr_q);

  // R6: mode strobe is one cycle wide
  p_mode_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_q |=> !mode_wr_q);

endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_t           cmd_i,
  input  logic [CW:0]    sel_data_i,
  input  logic [NCH-1:0] all_data_i,
  output logic [NCH-1:0] req_o,
  output logic [NCH-1:0] mask_o
);

  logic [NCH-1:0] req_q, mask_q;
  logic           new_val;
  logic [CW-1:0]  chan_sel;

  assign new_val  = sel_data_i[CW];
  assign chan_sel = sel_data_i[CW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit, req_d, mask_d, req_en, mask_en;

    always_comb begin
      hit     = (chan_sel == CW'(g));
      req_en  = cmd_i.mclr || (cmd_i.req_we && hit);
      req_d   = cmd_i.mclr ? 1'b0 : new_val;
      mask_en = cmd_i.mclr || cmd_i.mask_clr || cmd_i.mask_all ||
                (cmd_i.mask_we && hit);
      if (cmd_i.mclr)          mask_d = 1'b1;
      else if (cmd_i.mask_clr) mask_d = 1'b0;
      else if (cmd_i.mask_all) mask_d = all_data_i[g];
      else                     mask_d = new_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[g]  <= 1'b0;
        mask_q[g] <= 1'b1;
      end else begin
        if (req_en)  req_q[g]  <= req_d;
        if (mask_en) mask_q[g] <= mask_d;
      end
    end
  end

  assign req_o  = req_q;
  assign mask_o = mask_q;

  // R4: a single-flag write touches at most one request flag
  p_req_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.req_we |=> ($countones(req_q ^ $past(req_q)) <= 1));

  // R5: a single-flag write touches at most one mask flag
  p_mask_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.mask_we |=> ($countones(mask_q ^ $past(mask_q)) <= 1));

  // R9: clear-all empties the mask
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.mask_clr |=> (mask_q == '0));

  // R8: master clear restores the reset flags
  p_mclr_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i.mclr |=> (req_q == '0) && (&mask_q));

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  localparam int unsigned SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_stat_i,
  input  logic           rd_temp_i,
  input  logic [NCH-1:0] tc_i,
  input  logic [NCH-1:0] dreq_i,
  input  logic [NCH-1:0] req_i,
  input  logic [DW-1:0]  temp_i,
  output logic [DW-1:0]  rd_data_o
);

  logic [DW-1:0]  stat_word;
  logic [NCH-1:0] pending;

  always_comb begin
    pending   = dreq_i | req_i;
    stat_word = '0;
    stat_word[SW-1:0] = {pending, tc_i};
  end

  always_comb begin
    if (rd_stat_i)      rd_data_o = stat_word;
    else if (rd_temp_i) rd_data_o = temp_i;
    else                rd_data_o = '0;
  end

  // R11: nothing is returned outside a decoded read
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat_i && !rd_temp_i) |-> (rd_data_o == '0));

  // R3: a request flag always shows as pending in status
  p_stat_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_i |-> ((rd_data_o[SW-1:NCH] & req_i) == req_i));

endmodule

// File: rtl/dma_cmd_decoder.sv
module dma_cmd_decoder
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 4,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic [DW-1:0]  rd_data_o,
  input  logic [NCH-1:0] tc_i,
  input  logic [NCH-1:0] dreq_i,
  input  logic [DW-1:0]  temp_i,
  input  logic           ptr_toggle_i,
  output logic [DW-1:0]  ctrl_o,
  output logic [NCH-1:0] req_o,
  output logic [NCH-1:0] mask_o,
  output logic           ptr_o,
  output logic           mode_wr_o,
  output logic [DW-1:0]  mode_data_o
);

  logic rst_s0_q, rst_s1_q, rst_int_n;
  cmd_t cmd;
  logic rd_stat, rd_temp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_int_n = rst_s1_q;

  dma_addr_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_i(addr_i), .cmd_o(cmd), .rd_stat_o(rd_stat), .rd_temp_o(rd_temp)
  );

  dma_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_i(cmd), .wr_data_i(wr_data_i),
    .ptr_toggle_i(ptr_toggle_i), .ctrl_o(ctrl_o), .ptr_o(ptr_o),
    .mode_wr_o(mode_wr_o), .mode_data_o(mode_data_o)
  );

  dma_chan_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .cmd_i(cmd),
    .sel_data_i(wr_data_i[CW:0]), .all_data_i(wr_data_i[NCH-1:0]),
    .req_o(req_o), .mask_o(mask_o)
  );

  dma_read_mux #(.NCH(NCH), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .rd_stat_i(rd_stat), .rd_temp_i(rd_temp),
    .tc_i(tc_i), .dreq_i(dreq_i), .req_i(req_o), .temp_i(temp_i),
    .rd_data_o(rd_data_o)
  );

  // R1: reset leaves the block in its idle state
  p_reset_state_r1: assert property (@(posedge clk)
    (rst_int_n && !$past(rst_int_n)) |-> (ctrl_o == '0) && (req_o == '0) &&
    (&mask_o) && !ptr_o && !mode_wr_o);

endmodule

// File: tb/dma_cmd_decoder_test.sv
module dma_cmd_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n, ptr_toggle;
  logic [3:0] addr, tc, dreq;
  logic [7:0] wdata, temp;
  logic [7:0] rdata, ctrl, mode_data;
  logic [3:0] req, mask;
  logic       ptr, mode_wr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dma_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .tc_i(tc),
    .dreq_i(dreq), .temp_i(temp), .ptr_toggle_i(ptr_toggle),
    .ctrl_o(ctrl), .req_o(req), .mask_o(mask), .ptr_o(ptr),
    .mode_wr_o(mode_wr), .mode_data_o(mode_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 ctrl", ctrl, 8'h00);
    chk("R1 req", {4'h0, req}, 8'h00);
    chk("R1 mask", {4'h0, mask}, 8'h0F);
    chk("R1 ptr/mode", {6'h0, ptr, mode_wr}, 8'h00);
  endtask

  task automatic t_ctrl;
    wr(4'h8, 8'h2B);
    chk("R2 ctrl load", ctrl, 8'h2B);
    wr(4'h8, 8'hD4);
    chk("R2 ctrl reload", ctrl, 8'hD4);
  endtask

  task automatic t_req;
    wr(4'h9, 8'hF9);   // bit2=0 chan1 with junk upper bits: stays 0
    chk("R4 clear ignores upper", {4'h0, req}, 8'h00);
    wr(4'h9, 8'h06);   // set chan 2
    chk("R4 set ch2", {4'h0, req}, 8'h04);
    wr(4'h9, 8'hF4);   // set chan 0, upper junk
    chk("R4 set ch0", {4'h0, req}, 8'h05);
    wr(4'h9, 8'h02);   // clear chan 2
    chk("R4 clear ch2", {4'h0, req}, 8'h01);
  endtask

  task automatic t_status;
    logic [7:0] d;
    tc = 4'b1001; dreq = 4'b0100;
    rd(4'h8, d);
    chk("R3 status", d, 8'h59);   // pending = 0100|0001
    tc = 4'b0110; dreq = 4'b1000;
    rd(4'h8, d);
    chk("R3 status 2", d, 8'h96);
    tc = 4'h0; dreq = 4'h0;
  endtask

  task automatic t_mask;
    wr(4'hA, 8'h03);   // clear chan 3
    chk("R5 clear ch3", {4'h0, mask}, 8'h07);
    wr(4'hA, 8'hF8);   // clear chan 0, junk upper
    chk("R5 clear ch0", {4'h0, mask}, 8'h06);
    wr(4'hA, 8'h07);   // set chan 3
    chk("R5 set ch3", {4'h0, mask}, 8'h0E);
  endtask

  task automatic t_mask_bulk;
    wr(4'hE, 8'hFF);
    chk("R9 clear all", {4'h0, mask}, 8'h00);
    wr(4'hF, 8'hA5);
    chk("R9 load all", {4'h0, mask}, 8'h05);
    wr(4'hF, 8'h0A);
    chk("R9 load all 2", {4'h0, mask}, 8'h0A);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h5C);
    chk("R6 mode strobe", {7'h0, mode_wr}, 8'h01);
    chk("R6 mode data", mode_data, 8'h5C);
    @(negedge clk);
    chk("R6 strobe width", {7'h0, mode_wr}, 8'h00);
  endtask

  task automatic t_ptr;
    @(negedge clk); ptr_toggle = 1'b1;
    @(negedge clk); ptr_toggle = 1'b0;
    chk("R7 toggle", {7'h0, ptr}, 8'h01);
    wr(4'hC, 8'hFF);
    chk("R7 clear", {7'h0, ptr}, 8'h00);
    @(negedge clk); ptr_toggle = 1'b1;
    @(negedge clk); ptr_toggle = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 4'hC; ptr_toggle = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; ptr_toggle = 1'b0;
    chk("R7 clear wins", {7'h0, ptr}, 8'h00);
  endtask

  task automatic t_temp_mclr;
    logic [7:0] d;
    temp = 8'hC3;
    rd(4'hD, d);
    chk("R8 temp read", d, 8'hC3);
    wr(4'h8, 8'h11); wr(4'h9, 8'h05); wr(4'hE, 8'h00);
    @(negedge clk); ptr_toggle = 1'b1;
    @(negedge clk); ptr_toggle = 1'b0;
    wr(4'hD, 8'h00);
    chk("R8 mclr ctrl", ctrl, 8'h00);
    chk("R8 mclr req", {4'h0, req}, 8'h00);
    chk("R8 mclr mask", {4'h0, mask}, 8'h0F);
    chk("R8 mclr ptr", {7'h0, ptr}, 8'h00);
  endtask

  task automatic t_once;
    wr(4'h8, 8'h00);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 4'h8; wdata = 8'hFF;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    chk("R10 no chip select", ctrl, 8'h00);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 4'h8; wdata = 8'h21;
    @(negedge clk); wdata = 8'h3C;
    @(negedge clk); wdata = 8'h77;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    chk("R10 held strobe", ctrl, 8'h21);
    wr(4'h3, 8'hFF);
    chk("R10 unlisted ctrl", ctrl, 8'h21);
    chk("R10 unlisted flags", {req, mask}, 8'h0F);
  endtask

  task automatic t_unlisted;
    logic [7:0] d;
    tc = 4'hF; dreq = 4'hF; temp = 8'hEE;
    rd(4'h9, d);  chk("R11 read 0x9", d, 8'h00);
    rd(4'hE, d);  chk("R11 read 0xE", d, 8'h00);
    rd(4'h0, d);  chk("R11 read 0x0", d, 8'h00);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 4'h8;
    #1 chk("R11 no chip select", rdata, 8'h00);
    rd_n = 1'b1;
    tc = 4'h0; dreq = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 4'h0; wdata = 8'h00;
    tc = 4'h0; dreq = 4'h0; temp = 8'h00; ptr_toggle = 1'b0;
    t_reset();
    t_ctrl();
    t_req();
    t_status();
    t_mask();
    t_mask_bulk();
    t_mode();
    t_ptr();
    t_temp_mclr();
    t_once();
    t_unlisted();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule